// File: doc/BRIEF.md
# Flash Query-Mode Read Controller

This block sits in a cartridge read path and produces one 16-bit read word per cycle from a registered byte address. By default it passes words through from the ROM behind it. Reads at or past the ROM size return zero. The host writes a word pointer into the block and can then step it forward by one word at a time.

The block also watches the cartridge write bus for two command patterns. One puts the read path into a sticky flash query mode, and the other takes it out again. While query mode is on, a read whose chip-select field falls below a chip count taken from the board ID is served from a built-in flash query table, not from ROM. A separate output always presents the board ID with its low seven bits masked off.

Top module: `flash_qry_rd`

## Requirements
- R1: A cycle with `wr_en` high, `wr_offset` = 0x00AA and `wr_data` = 0x0098 switches query mode on.
- R2: A cycle with `wr_en` high, `wr_offset` = 0x0000 and `wr_data` = 0x00F0 switches query mode off.
- R3: Any other write, or a cycle without `wr_en`, leaves query mode unchanged.
- R4: A mode change is first seen by reads in the cycle after the command write. A read in the same cycle as the write still uses the old mode.
- R5: In query mode, a read whose chip field (byte-address bits 28:26) is less than ID bits 6:0 (4 by default) returns `{8'h00, T[a]}`. Here a is byte-address bits 15:0 and T is the query table: 0x51,0x52,0x59,0x02 at byte 32..38 step 2; 0x40@42, 0x27@54, 0x36@56, 0x07@62, 0x07@64, 0x0A@66, 0x01@70, 0x05@72, 0x04@74, 0x1A@78, 0x02@80, 0x05@84, 0x01@88, 0xFF@90, 0x01@92, 0x02@96; 0x50,0x52,0x49,0x31,0x33,0x10,0x02,0x01 at byte 128..142 step 2; 0x08@146, 0x02@152, 0xB5@154, 0xC5@156, 0x04@158, 0x01@160. Every other entry is 0x00.
- R6: Query-table indices at or beyond byte 162 read as 0x0000.
- R7: In query mode, a read whose chip field is not below the chip count takes the normal ROM/zero path.
- R8: On the normal path, when `rom_addr` < `rom_size`, `rd_data` equals `rom_data`.
- R9: On the normal path, when `rom_addr` >= `rom_size`, `rd_data` is 0x0000.
- R10: `id_rdata` is the board ID with bits 6:0 forced to zero (0x5500 for the default ID 0x5504).
- R11: A synchronous active-low reset clears query mode and sets `rom_addr` to 0.
- R12: `ld_en` loads `rom_addr` = `{ld_word, 1'b0}`. Otherwise `adv_en` adds 2 to `rom_addr`. When both are high, `ld_en` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe on the cartridge bus |
| wr_offset | input | 16 | Low 16 bits of the write offset |
| wr_data | input | 16 | Write data |
| ld_en | input | 1 | Load the read pointer |
| ld_word | input | 28 | Word address to load |
| adv_en | input | 1 | Step the read pointer by one word |
| rom_size | input | 32 | ROM size in bytes |
| rom_data | input | 16 | Word read from ROM at `rom_addr` |
| rom_addr | output | 29 | Current byte address (always even) |
| rd_data | output | 16 | Read word |
| id_rdata | output | 16 | Masked board ID |

## Verification
On every cycle, the assertions check the following:
- Each command pattern sets or clears the mode on the next edge.
- The mode holds its value while no write happens.
- The pointer stays word aligned.
- The ID output keeps its low bits clear.
- A normal-path read past the ROM end yields zero.

Only the bench scenarios can show the other behaviours:
- The contents of the query table, including the end of the table.
- The chip-count boundary.
- A read in the same cycle as a command write, which still sees the old mode.
- Clearing of the mode and the pointer by a mid-run reset.

// File: rtl/fqr_pkg.sv
// Package: shared types and the query-table content function.
// Assumes byte-wide table entries at even byte offsets; odd bytes are zero.
package fqr_pkg;
    typedef enum logic {MODE_ARRAY = 1'b0, MODE_QUERY = 1'b1} fqr_mode_e;

    localparam int QRY_BYTES = 162;

    // Table byte at even byte index 2*widx; zero for any word index not listed.
    function automatic logic [7:0] qry_byte(input logic [14:0] widx);
        logic [7:0] b;
        case (widx)
            15'd16: b = 8'h51;  15'd17: b = 8'h52;  15'd18: b = 8'h59;
            15'd19: b = 8'h02;  15'd21: b = 8'h40;  15'd27: b = 8'h27;
            15'd28: b = 8'h36;  15'd31: b = 8'h07;  15'd32: b = 8'h07;
            15'd33: b = 8'h0a;  15'd35: b = 8'h01;  15'd36: b = 8'h05;
            15'd37: b = 8'h04;  15'd39: b = 8'h1a;  15'd40: b = 8'h02;
            15'd42: b = 8'h05;  15'd44: b = 8'h01;  15'd45: b = 8'hff;
            15'd46: b = 8'h01;  15'd48: b = 8'h02;  15'd64: b = 8'h50;
            15'd65: b = 8'h52;  15'd66: b = 8'h49;  15'd67: b = 8'h31;
            15'd68: b = 8'h33;  15'd69: b = 8'h10;  15'd70: b = 8'h02;
            15'd71: b = 8'h01;  15'd73: b = 8'h08;  15'd76: b = 8'h02;
            15'd77: b = 8'hb5;  15'd78: b = 8'hc5;  15'd79: b = 8'h04;
            15'd80: b = 8'h01;
            default: b = 8'h00;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/fqr_cmd_decode.sv
// Command decoder: watches the write bus and holds the sticky query-mode flag.
// Assumes the enter and leave patterns can never match in the same cycle.
module fqr_cmd_decode #(
    parameter int          OFS_W      = 16,
    parameter int          DAT_W      = 16,
    parameter logic [15:0] ENTER_OFS  = 16'h00AA,
    parameter logic [15:0] ENTER_DATA = 16'h0098,
    parameter logic [15:0] LEAVE_OFS  = 16'h0000,
    parameter logic [15:0] LEAVE_DATA = 16'h00F0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] wr_offset,
    input  logic [DAT_W-1:0] wr_data,
    output fqr_pkg::fqr_mode_e mode_q
);
    import fqr_pkg::*;

    logic hit_enter, hit_leave;

    // Match the two command patterns on the current write.
    always_comb begin
        hit_enter = wr_en && (wr_offset == OFS_W'(ENTER_OFS)) && (wr_data == DAT_W'(ENTER_DATA));
        hit_leave = wr_en && (wr_offset == OFS_W'(LEAVE_OFS)) && (wr_data == DAT_W'(LEAVE_DATA));
    end

    // Update the mode register; other writes leave it as it is.
    always_ff @(posedge clk) begin
        if (!rst_n)         mode_q <= MODE_ARRAY;
        else if (hit_enter) mode_q <= MODE_QUERY;
        else if (hit_leave) mode_q <= MODE_ARRAY;
    end
endmodule

// File: rtl/fqr_addr_ptr.sv
// Read pointer: holds a word address, loaded or stepped by one word.
// Assumes a load takes priority over a step in the same cycle.
module fqr_addr_ptr #(
    parameter int WORD_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [WORD_W-1:0] ld_word,
    input  logic              adv_en,
    output logic [WORD_W:0]   byte_addr
);
    logic [WORD_W-1:0] word_q;

    // Hold, load or step the word pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)      word_q <= '0;
        else if (ld_en)  word_q <= ld_word;
        else if (adv_en) word_q <= word_q + 1'b1;
    end

    // Present the pointer as an even byte address.
    assign byte_addr = {word_q, 1'b0};
endmodule

// File: rtl/fqr_read_sel.sv
// Read selector: chooses the query table, ROM data or zero for the current address.
// Assumes byte_addr is even; chip enables are derived from CHIP_CNT at elaboration.
module fqr_read_sel #(
    parameter int ADDR_W   = 29,
    parameter int SIZE_W   = 32,
    parameter int CHIP_LSB = 26,
    parameter int CHIP_W   = 3,
    parameter int CHIP_CNT = 4
) (
    input  fqr_pkg::fqr_mode_e mode,
    input  logic [ADDR_W-1:0]  byte_addr,
    input  logic [SIZE_W-1:0]  rom_size,
    input  logic [15:0]        rom_data,
    output logic [15:0]        rd_data
);
    import fqr_pkg::*;

    localparam int NCHIP = 1 << CHIP_W;

    logic [NCHIP-1:0]  chip_en;
    logic [CHIP_W-1:0] chip_fld;
    logic              qry_hit;
    logic              in_rom;
    logic [7:0]        qbyte;

    // One enable lane per chip field value: enabled when below the chip count.
    for (genvar i = 0; i < NCHIP; i++) begin : g_chip
        assign chip_en[i] = (i < CHIP_CNT);
    end

    // Decide which source serves the current address.
    always_comb begin
        chip_fld = byte_addr[CHIP_LSB +: CHIP_W];
        qry_hit  = (mode == MODE_QUERY) && chip_en[chip_fld];
        in_rom   = (SIZE_W'(byte_addr) < rom_size);
        qbyte    = qry_byte(byte_addr[15:1]);
    end

    // Drive the read word from the chosen source.
    always_comb begin
        if (qry_hit)     rd_data = {8'h00, qbyte};
        else if (in_rom) rd_data = rom_data;
        else             rd_data = 16'h0000;
    end
endmodule

// File: rtl/flash_qry_rd.sv
// Top: flash query-mode read controller.
// Ties together the command decoder, the read pointer and the read selector,
// and exports the masked board ID. Assumes a synchronous active-low reset.
module flash_qry_rd #(
    parameter logic [15:0] BOARD_ID = 16'h5504,
    parameter int          WORD_W   = 28,
    parameter int          SIZE_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [15:0]       wr_offset,
    input  logic [15:0]       wr_data,
    input  logic              ld_en,
    input  logic [WORD_W-1:0] ld_word,
    input  logic              adv_en,
    input  logic [SIZE_W-1:0] rom_size,
    input  logic [15:0]       rom_data,
    output logic [WORD_W:0]   rom_addr,
    output logic [15:0]       rd_data,
    output logic [15:0]       id_rdata
);
    import fqr_pkg::*;

    localparam int ADDR_W   = WORD_W + 1;
    localparam int CHIP_CNT = int'(BOARD_ID[6:0]);

    fqr_mode_e mode_q;

    fqr_cmd_decode u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_offset (wr_offset),
        .wr_data   (wr_data),
        .mode_q    (mode_q)
    );

    fqr_addr_ptr #(.WORD_W(WORD_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_en     (ld_en),
        .ld_word   (ld_word),
        .adv_en    (adv_en),
        .byte_addr (rom_addr)
    );

    fqr_read_sel #(
        .ADDR_W   (ADDR_W),
        .SIZE_W   (SIZE_W),
        .CHIP_CNT (CHIP_CNT)
    ) u_sel (
        .mode      (mode_q),
        .byte_addr (rom_addr),
        .rom_size  (rom_size),
        .rom_data  (rom_data),
        .rd_data   (rd_data)
    );

    // Board ID readback with the chip-count bits masked.
    assign id_rdata = BOARD_ID & 16'hFF80;
endmodule

// File: rtl/flash_qry_rd_chk.sv
// Checker: temporal properties of the query-mode read controller, bound to the top.
module flash_qry_rd_chk #(
    parameter logic [15:0] BOARD_ID = 16'h5504,
    parameter int          WORD_W   = 28,
    parameter int          SIZE_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [15:0]       wr_offset,
    input logic [15:0]       wr_data,
    input logic              mode,
    input logic [WORD_W:0]   rom_addr,
    input logic [SIZE_W-1:0] rom_size,
    input logic [15:0]       rd_data,
    input logic [15:0]       id_rdata
);
    logic qsel;
    assign qsel = mode && ({4'b0, rom_addr[28:26]} < BOARD_ID[6:0]);

    p_enter_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_offset == 16'h00AA && wr_data == 16'h0098) |=> mode);

    p_leave_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_offset == 16'h0000 && wr_data == 16'h00F0) |=> !mode);

    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mode));

    p_past_end_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!qsel && SIZE_W'(rom_addr) >= rom_size) |-> rd_data == 16'h0000);

    p_id_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        id_rdata[6:0] == 7'd0);

    p_aligned_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rom_addr[0] == 1'b0);
endmodule

bind flash_qry_rd flash_qry_rd_chk #(
    .BOARD_ID (BOARD_ID),
    .WORD_W   (WORD_W),
    .SIZE_W   (SIZE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_offset (wr_offset),
    .wr_data   (wr_data),
    .mode      (mode_q == fqr_pkg::MODE_QUERY),
    .rom_addr  (rom_addr),
    .rom_size  (rom_size),
    .rd_data   (rd_data),
    .id_rdata  (id_rdata)
);

// File: tb/flash_qry_rd_tb_top.sv
module flash_qry_rd_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_offset = '0;
    logic [15:0] wr_data = '0;
    logic        ld_en = 1'b0;
    logic [27:0] ld_word = '0;
    logic        adv_en = 1'b0;
    logic [31:0] rom_size = 32'h1000;
    logic [15:0] rom_data;
    logic [28:0] rom_addr;
    logic [15:0] rd_data;
    logic [15:0] id_rdata;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // Bench model state
    bit          m_mode = 1'b0;
    logic [28:0] m_addr = '0;

    always #5 clk = ~clk;

    function automatic logic [15:0] rom_model(input logic [28:0] a);
        return a[16:1] ^ 16'h3C5A;
    endfunction

    assign rom_data = rom_model(rom_addr);

    flash_qry_rd dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_offset(wr_offset),
        .wr_data(wr_data), .ld_en(ld_en), .ld_word(ld_word), .adv_en(adv_en),
        .rom_size(rom_size), .rom_data(rom_data), .rom_addr(rom_addr),
        .rd_data(rd_data), .id_rdata(id_rdata)
    );

    // Query table as stated in R5 (value at byte index a; zero elsewhere, R6)
    function automatic logic [7:0] tbl(input int a);
        case (a)
            32: return 8'h51; 34: return 8'h52; 36: return 8'h59; 38: return 8'h02;
            42: return 8'h40; 54: return 8'h27; 56: return 8'h36; 62: return 8'h07;
            64: return 8'h07; 66: return 8'h0a; 70: return 8'h01; 72: return 8'h05;
            74: return 8'h04; 78: return 8'h1a; 80: return 8'h02; 84: return 8'h05;
            88: return 8'h01; 90: return 8'hff; 92: return 8'h01; 96: return 8'h02;
            128: return 8'h50; 130: return 8'h52; 132: return 8'h49; 134: return 8'h31;
            136: return 8'h33; 138: return 8'h10; 140: return 8'h02; 142: return 8'h01;
            146: return 8'h08; 152: return 8'h02; 154: return 8'hb5; 156: return 8'hc5;
            158: return 8'h04; 160: return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [15:0] exp_rd(input bit md, input logic [28:0] a, input logic [31:0] sz);
        if (md && a[28:26] < 3'd4) return {8'h00, tbl(int'(a[15:0]))};
        if ({3'b0, a} < sz) return rom_model(a);
        return 16'h0000;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_rd(input string req);
        chk({16'h0, rd_data}, {16'h0, exp_rd(m_mode, m_addr, rom_size)}, req);
    endtask

    // One cycle of stimulus: drive after negedge, clock, settle after next negedge
    task automatic cycle_idle();
        @(negedge clk); #1;
    endtask

    task automatic do_write(input logic [15:0] ofs, input logic [15:0] dat);
        wr_en = 1'b1; wr_offset = ofs; wr_data = dat;
        @(negedge clk);
        wr_en = 1'b0;
        if (ofs == 16'h00AA && dat == 16'h0098) m_mode = 1'b1;
        else if (ofs == 16'h0000 && dat == 16'h00F0) m_mode = 1'b0;
        #1;
    endtask

    task automatic do_load(input logic [27:0] w);
        ld_en = 1'b1; ld_word = w;
        @(negedge clk);
        ld_en = 1'b0;
        m_addr = {w, 1'b0};
        #1;
    endtask

    task automatic do_adv();
        adv_en = 1'b1;
        @(negedge clk);
        adv_en = 1'b0;
        m_addr = m_addr + 29'd2;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // Reset state
        chk({3'b0, rom_addr}, 32'h0, "R11 addr after reset");
        chk_rd("R11 mode off after reset");
        chk({16'h0, id_rdata}, 32'h5500, "R10 id mask");

        // Enter query: same-cycle read uses old mode (R4)
        do_load(28'h10);
        wr_en = 1'b1; wr_offset = 16'h00AA; wr_data = 16'h0098; #1;
        chk({16'h0, rd_data}, {16'h0, rom_model(29'h20)}, "R4 same-cycle old mode");
        @(negedge clk); wr_en = 1'b0; m_mode = 1'b1; #1;
        chk({16'h0, rd_data}, 32'h0051, "R1 R5 query byte 32");

        // Near-miss command ignored
        do_write(16'h00AA, 16'h0099);
        chk({16'h0, rd_data}, 32'h0051, "R3 near-miss write ignored");
        do_write(16'h0000, 16'h00F1);
        chk({16'h0, rd_data}, 32'h0051, "R3 near-miss leave ignored");

        // Table end
        do_load(28'd80);
        chk({16'h0, rd_data}, 32'h0001, "R5 last entry");
        do_load(28'd81);
        chk({16'h0, rd_data}, 32'h0000, "R6 beyond table");

        // Chip field boundary
        do_load((28'd3 << 25) | 28'h10);
        chk({16'h0, rd_data}, 32'h0051, "R5 chip field 3 served");
        do_load((28'd4 << 25) | 28'h10);
        chk({16'h0, rd_data}, 32'h0000, "R7 R9 chip field 4 past rom");
        rom_size = 32'h2000_0000; #1;
        chk({16'h0, rd_data}, {16'h0, rom_model({(28'd4 << 25) | 28'h10, 1'b0})}, "R7 R8 chip field 4 rom");

        // Leave query
        do_load(28'h10);
        do_write(16'h0000, 16'h00F0);
        chk({16'h0, rd_data}, {16'h0, rom_model(29'h20)}, "R2 left query");

        // Pointer and rom boundary
        rom_size = 32'd12;
        do_load(28'd5);
        chk({3'b0, rom_addr}, 32'd10, "R12 load");
        chk_rd("R8 below size");
        do_adv();
        chk({3'b0, rom_addr}, 32'd12, "R12 advance");
        chk({16'h0, rd_data}, 32'h0, "R9 at size");
        rom_size = 32'd13; #1;
        chk_rd("R8 size just above");

        // Load wins over advance
        ld_en = 1'b1; adv_en = 1'b1; ld_word = 28'd40;
        @(negedge clk); ld_en = 1'b0; adv_en = 1'b0; m_addr = 29'd80; #1;
        chk({3'b0, rom_addr}, 32'd80, "R12 load priority");

        // Mid-run reset clears mode and address
        do_write(16'h00AA, 16'h0098);
        rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; m_mode = 1'b0; m_addr = '0; #1;
        chk({3'b0, rom_addr}, 32'h0, "R11 mid-run reset addr");
        do_load(28'h10);
        rom_size = 32'h1000; #1;
        chk({16'h0, rd_data}, {16'h0, rom_model(29'h20)}, "R11 mode cleared");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int sel;
            sel = int'($urandom_range(0, 9));
            if (sel < 2)       do_write(16'h00AA, 16'h0098);
            else if (sel < 3)  do_write(16'h0000, 16'h00F0);
            else if (sel < 4)  do_write(16'($urandom), 16'($urandom));
            else if (sel < 7)  do_load({25'($urandom_range(0, 7)) << 25} | 28'($urandom_range(0, 120)));
            else if (sel < 8)  do_adv();
            else begin rom_size = $urandom_range(0, 300); cycle_idle(); end
            chk_rd("R5 R8 R9 random read");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        process::self().srandom(32'd1234);
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule